// File: doc/BRIEF.md
# Codec Register Access Request Controller

This block is the processor-facing half of an audio codec's register access path. Software writes the codec register number and, for a store, the value to send into two holding registers. It then writes the control word with its request bit set. A direction flag in the same word selects the operation. A store raises a one-cycle pulse on the store interrupt line, and a fetch raises a one-cycle pulse on the fetch interrupt line. The request bit is never stored, so it always reads back as zero.

The block sits on a simple single-cycle memory-mapped slave port that carries byte addresses and byte enables. Only full 32-bit, word-aligned accesses to the four mapped words take effect. Any other access is dropped, reads as zero and raises a one-cycle error pulse. Read data is registered and appears one cycle after the request, together with a valid strobe.

Top module: `codec_req_ctrl`

## Requirements
- R1: After reset, all four registers read as zero, and both interrupt lines, the error line and the read-valid strobe are low.
- R2: The word is chosen by byte address bits [ADDR_W-1:2]: byte 0x0 is control, 0x4 is codec register number, 0x8 is outgoing data and 0xC is returned data; each is a separate storage word.
- R3: The codec register number, outgoing data and returned data words hold the last full-word value written and read it back unchanged.
- R4: A control write with bit 0 (request) = 1 and bit 1 (direction) = 1 drives irq_store high for exactly the one cycle after the write edge, and irq_fetch stays low.
- R5: A control write with bit 0 = 1 and bit 1 = 0 drives irq_fetch high for exactly the one cycle after the write edge, and irq_store stays low.
- R6: The control word stores all written bits except bit 0, which always reads back 0.
- R7: A control write with bit 0 = 0 updates the stored control word, including bit 1, and produces no interrupt pulse.
- R8: An access to a word offset of 4 or above, or to a byte address with bits [1:0] not zero, changes no register. If it is a read it returns zero, and in either case bus_err goes high for the one cycle after the access.
- R9: An access with any byte enable clear is treated as in R8: it is dropped, it reads as zero and it raises bus_err.
- R10: Every read, mapped or not, gives bus_rvalid high with its data on bus_rdata in the cycle after the request. Writes never raise bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | DATA_W/8 | Byte enables; all must be set |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_err | output | 1 | Rejected access pulse |
| irq_store | output | 1 | Store request pulse |
| irq_fetch | output | 1 | Fetch request pulse |

## Verification
The bench sets bits 0 and 1 of the control word in each of their combinations. This would catch a design that swaps the two interrupt lines, pulses on a write with the request bit clear, or stores the request bit. It also writes two requests back to back and checks that the pulse drops afterwards, which catches a line that latches high instead of pulsing. Distinct values written to every word catch offset aliasing. Partial byte enables, misaligned addresses and offsets beyond the map catch a design that lets a dropped access corrupt a register or return stale data.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int NUM_WORDS = 4;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_CADR = 3'd1,
    SEL_TXD  = 3'd2,
    SEL_RXD  = 3'd3,
    SEL_NONE = 3'd4
  } word_sel_e;

  // Request and direction bit positions in the control word.
  localparam int BIT_REQ = 0;
  localparam int BIT_DIR = 1;

  function automatic word_sel_e sel_of(input logic [29:0] word_idx);
    case (word_idx)
      30'd0:   return SEL_CTRL;
      30'd1:   return SEL_CADR;
      30'd2:   return SEL_TXD;
      30'd3:   return SEL_RXD;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic [31:0] strip_req(input logic [31:0] v);
    logic [31:0] r;
    r = v;
    r[BIT_REQ] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/acr_decode.sv
module acr_decode #(
  parameter int ADDR_W = 8,
  parameter int BE_W   = 4
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output acr_pkg::word_sel_e sel,
  output logic              hit,
  output logic              reject
);
  import acr_pkg::*;
  logic [29:0] word_idx;
  logic        aligned;
  logic        full;

  always_comb begin
    word_idx = '0;
    word_idx[ADDR_W-3:0] = addr[ADDR_W-1:2];
  end

  assign aligned = (addr[1:0] == 2'b00);
  assign full    = &be;
  assign sel     = sel_of(word_idx);
  assign hit     = valid && aligned && full && (sel != SEL_NONE);
  assign reject  = valid && !hit;
endmodule

// File: rtl/acr_regfile.sv
module acr_regfile #(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  acr_pkg::word_sel_e sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               rvalid,
  output logic [DATA_W-1:0]  ctrl_word
);
  import acr_pkg::*;
  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] rd_mux;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (wr_en && sel == word_sel_e'(g)) begin
        if (g == 0) words[g] <= strip_req(wdata);
        else        words[g] <= wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel != SEL_NONE) rd_mux = words[sel[1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? rd_mux : '0;
    end
  end

  assign ctrl_word = words[0];
endmodule

// File: rtl/acr_pulse.sv
module acr_pulse #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  output logic [N-1:0] pulse
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) pulse[g] <= 1'b0;
      else        pulse[g] <= ev[g];
    end
  end
endmodule

// File: rtl/codec_req_ctrl.sv
module codec_req_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic              irq_store,
  output logic              irq_fetch
);
  import acr_pkg::*;

  word_sel_e         sel;
  logic              hit;
  logic              reject;
  logic              ev_wr;
  logic              ev_rd;
  logic              ev_ctrl_wr;
  logic              ev_req_store;
  logic              ev_req_fetch;
  logic [DATA_W-1:0] ctrl_word;
  logic [2:0]        pulses;

  acr_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .valid(bus_valid), .addr(bus_addr), .be(bus_be),
    .sel(sel), .hit(hit), .reject(reject)
  );

  assign ev_wr        = hit && bus_write;
  assign ev_rd        = bus_valid && !bus_write;
  assign ev_ctrl_wr   = ev_wr && (sel == SEL_CTRL);
  assign ev_req_store = ev_ctrl_wr && bus_wdata[BIT_REQ] && bus_wdata[BIT_DIR];
  assign ev_req_fetch = ev_ctrl_wr && bus_wdata[BIT_REQ] && !bus_wdata[BIT_DIR];

  acr_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ev_wr), .rd_en(ev_rd),
    .sel(hit ? sel : SEL_NONE), .wdata(bus_wdata),
    .rdata(bus_rdata), .rvalid(bus_rvalid), .ctrl_word(ctrl_word)
  );

  acr_pulse #(.N(3)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .ev({reject, ev_req_fetch, ev_req_store}),
    .pulse(pulses)
  );

  assign irq_store = pulses[0];
  assign irq_fetch = pulses[1];
  assign bus_err   = pulses[2];
endmodule

// File: rtl/acr_checker.sv
module acr_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BE_W-1:0]   bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic              irq_store,
  input logic              irq_fetch,
  input logic [DATA_W-1:0] ctrl_word
);
  logic prev_ctrl_wr;
  logic prev_bad;
  assign prev_ctrl_wr = bus_valid && bus_write && (bus_addr == '0) && (&bus_be);
  assign prev_bad = bus_valid && ((bus_addr[1:0] != 2'b00) || !(&bus_be) ||
                                  (bus_addr[ADDR_W-1:2] > 3));

  assert_store_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_store |-> $past(prev_ctrl_wr && bus_wdata[0] && bus_wdata[1]));
  assert_fetch_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fetch |-> $past(prev_ctrl_wr && bus_wdata[0] && !bus_wdata[1]));
  assert_irq_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_store, irq_fetch}));
  assert_req_bit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[0] == 1'b0);
  assert_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ctrl_wr && !bus_wdata[0]) |=> !(irq_store || irq_fetch));
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(prev_bad));
  assert_rvalid_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write));
endmodule

bind codec_req_ctrl acr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_rvalid(bus_rvalid), .bus_err(bus_err), .irq_store(irq_store),
  .irq_fetch(irq_fetch), .ctrl_word(ctrl_word)
);

// File: tb/tb_codec_req_ctrl.sv
module tb_codec_req_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err, irq_store, irq_fetch;

  int checks = 0;
  int fails  = 0;
  logic        s_store, s_fetch, s_err, s_rvalid;
  logic [31:0] s_rdata;

  always #2.5 clk = ~clk;

  codec_req_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .irq_store(irq_store), .irq_fetch(irq_fetch)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge capture, sample at the next falling edge.
  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] be);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    s_store = irq_store; s_fetch = irq_fetch; s_err = bus_err;
    s_rvalid = bus_rvalid; s_rdata = bus_rdata;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    access(1'b0, a, 32'h0, 4'hF);
    d = s_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_store", {31'b0, irq_store}, 0);
    chk("R1 irq_fetch", {31'b0, irq_fetch}, 0);
    chk("R1 bus_err", {31'b0, bus_err}, 0);
    chk("R1 rvalid", {31'b0, bus_rvalid}, 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'(i * 4), d);
      chk("R1 reg zero", d, 0);
    end
  endtask

  task automatic t_data_regs;
    logic [31:0] d;
    access(1'b1, 8'h4, 32'h0000_0A5C, 4'hF);
    chk("R10 no rvalid on write", {31'b0, s_rvalid}, 0);
    access(1'b1, 8'h8, 32'hDEAD_BEEF, 4'hF);
    access(1'b1, 8'hC, 32'h1234_5678, 4'hF);
    access(1'b1, 8'h0, 32'h0000_0F00, 4'hF);
    rd(8'h4, d); chk("R3 codec addr", d, 32'h0000_0A5C);
    chk("R10 rvalid on read", {31'b0, s_rvalid}, 1);
    rd(8'h8, d); chk("R3 tx data", d, 32'hDEAD_BEEF);
    rd(8'hC, d); chk("R3 rx data", d, 32'h1234_5678);
    rd(8'h0, d); chk("R2 ctrl distinct", d, 32'h0000_0F00);
    access(1'b1, 8'h8, 32'hFFFF_FFFF, 4'hF);
    rd(8'h4, d); chk("R2 no alias", d, 32'h0000_0A5C);
    rd(8'h8, d); chk("R3 tx overwrite", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_store_req;
    logic [31:0] d;
    access(1'b1, 8'h0, 32'hFFFF_FFFF, 4'hF);
    chk("R4 store pulse", {31'b0, s_store}, 1);
    chk("R4 fetch quiet", {31'b0, s_fetch}, 0);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'b0, irq_store}, 0);
    rd(8'h0, d); chk("R6 req bit cleared", d, 32'hFFFF_FFFE);
  endtask

  task automatic t_fetch_req;
    logic [31:0] d;
    access(1'b1, 8'h0, 32'h0000_0001, 4'hF);
    chk("R5 fetch pulse", {31'b0, s_fetch}, 1);
    chk("R5 store quiet", {31'b0, s_store}, 0);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'b0, irq_fetch}, 0);
    rd(8'h0, d); chk("R6 reads zero", d, 32'h0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h0; bus_be = 4'hF;
    bus_wdata = 32'h3;
    @(negedge clk);
    chk("R4 first pulse", {31'b0, irq_store}, 1);
    bus_wdata = 32'h1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk("R5 second pulse", {30'b0, irq_fetch, irq_store}, 32'h2);
    @(negedge clk);
    chk("R5 both low after", {30'b0, irq_fetch, irq_store}, 0);
  endtask

  task automatic t_no_req;
    logic [31:0] d;
    access(1'b1, 8'h0, 32'h0000_0002, 4'hF);
    chk("R7 no pulse", {30'b0, s_fetch, s_store}, 0);
    rd(8'h0, d); chk("R7 dir stored", d, 32'h2);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    access(1'b1, 8'h10, 32'h5555_5555, 4'hF);
    chk("R8 err on unmapped write", {31'b0, s_err}, 1);
    chk("R8 no pulse", {30'b0, s_fetch, s_store}, 0);
    rd(8'h10, d);
    chk("R8 unmapped read zero", d, 0);
    chk("R8 err on unmapped read", {31'b0, s_err}, 1);
    chk("R10 rvalid unmapped read", {31'b0, s_rvalid}, 1);
    access(1'b1, 8'h5, 32'h7777_7777, 4'hF);
    chk("R8 err misaligned", {31'b0, s_err}, 1);
    rd(8'h4, d); chk("R8 no effect", d, 32'h0000_0A5C);
    chk("R8 err clears", {31'b0, s_err}, 0);
    access(1'b1, 8'h0, 32'h0000_0003, 4'hF);
    chk("R8 ctrl ok after bad", {31'b0, s_store}, 1);
  endtask

  task automatic t_partial;
    logic [31:0] d;
    access(1'b1, 8'hC, 32'hAAAA_AAAA, 4'h3);
    chk("R9 err partial write", {31'b0, s_err}, 1);
    rd(8'hC, d); chk("R9 write dropped", d, 32'h1234_5678);
    access(1'b1, 8'h0, 32'h0000_0003, 4'h7);
    chk("R9 no pulse partial ctrl", {30'b0, s_fetch, s_store}, 0);
    access(1'b0, 8'h8, 32'h0, 4'h1);
    chk("R9 partial read zero", s_rdata, 0);
    chk("R9 partial read err", {31'b0, s_err}, 1);
  endtask

  initial begin : watchdog
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_regs();
    t_store_req();
    t_fetch_req();
    t_back_to_back();
    t_no_req();
    t_unmapped();
    t_partial();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule